// File: doc/BRIEF.md
# Gate-In-Panel Clock Sequencer

This block produces the logic-level control set for a panel whose row drivers are built into the glass. At the start of each frame it issues a one-line-wide vertical start pulse, then steps six gate clock phases, one per line, in a fixed rotated order. The order reverses when the picture is scanned upside down. It stops after the last of the panel's rows. It also sets the two scan-direction levels and alternates the odd and even row-supply enables from frame to frame. Those enables change only inside vertical blanking, and there is always a dead cycle between them.

The host timing generator supplies a single clock, a line strobe, a frame strobe, a blanking flag, a rotate select and an enable. All outputs are active-high logic levels. An external level shifter maps them to the gate rails.

Top module: `gip_clock_seq`

## Requirements
- R1: While `en` is low, every output (`vst`, `gclk`, `vgi_p`, `vgi_n`, `vgh_odd`, `vgh_even`) is low.
- R2: While `en` is high, `vgi_p` = 1 and `vgi_n` = 0 when `rot` = 0, and `vgi_p` = 0 and `vgi_n` = 1 when `rot` = 1.
- R3: After a frame strobe, the first counted line strobe raises `vst`. It stays high for exactly that line period, until the next counted line strobe, and no gate clock is high meanwhile.
- R4: With normal direction, each counted line strobe after `vst` makes exactly one gate clock high. `gclk[0]` is GCLK1 and `gclk[5]` is GCLK6. The clocks follow the order GCLK4, GCLK5, GCLK6, GCLK1, GCLK2, GCLK3, repeating every six lines.
- R5: With reverse direction, the order is GCLK3, GCLK2, GCLK1, GCLK6, GCLK5, GCLK4, repeating every six lines.
- R6: The scan direction used for the gate clocks is the value of `rot` captured at the frame strobe. A change of `rot` mid-frame does not alter the running sequence.
- R7: After NUM_LINES gate clock pulses (default 1080), all gate clocks stay low until the next frame strobe.
- R8: A line strobe while `vblank` is high is ignored: `vst` and `gclk` keep their values.
- R9: In the cycle `en` is first high, `vgh_odd` = 1 and `vgh_even` = 0. The two are never high together.
- R10: A frame strobe while `vblank` is high drops the active supply enable in the next cycle. The other enable rises one cycle later, provided `vblank` is still high; otherwise both stay low until `vblank` returns high.
- R11: A frame strobe while `vblank` is low leaves the supply enables unchanged, but still restarts the line sequence.
- R12: When a frame strobe and a line strobe arrive in the same cycle, the frame strobe wins: the line sequence restarts and that line strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| rot | input | 1 | Rotate (reverse scan) select |
| line_stb | input | 1 | One-cycle line strobe |
| frame_stb | input | 1 | One-cycle frame (vsync) strobe |
| vblank | input | 1 | Vertical blanking flag |
| vst | output | 1 | Vertical start pulse |
| gclk | output | 6 | Gate clocks, bit 0 = GCLK1 |
| vgi_p | output | 1 | Scan-direction level, high in normal scan |
| vgi_n | output | 1 | Scan-direction level, high in rotated scan |
| vgh_odd | output | 1 | Odd-row supply enable |
| vgh_even | output | 1 | Even-row supply enable |

## Verification
A frame strobe can coincide with a line strobe, and a frame strobe can land in or out of blanking while a line strobe lands inside blanking. The bench forces these coincidences as directed cases inside otherwise random line spacing. A frame strobe together with a line strobe must restart the count without counting the line (R12). A line strobe in blanking must leave `vst` and `gclk` untouched while the supply swap proceeds (R8, R10). Each case is judged against a bench model that is updated cycle by cycle from the requirements.

// File: rtl/gip_pkg.sv
package gip_pkg;
  localparam int unsigned PHASES = 6;

  typedef enum logic [1:0] {
    SUP_ODD   = 2'd0,
    SUP_GAP_E = 2'd1,
    SUP_EVEN  = 2'd2,
    SUP_GAP_O = 2'd3
  } sup_state_e;

  // position within the six-line cycle -> gate clock index (0 = GCLK1)
  function automatic logic [2:0] gate_index(input logic [2:0] pos, input logic rev);
    logic [3:0] t;
    if (rev) t = (4'd8 - {1'b0, pos}) % 4'd6;
    else     t = (4'd3 + {1'b0, pos}) % 4'd6;
    return t[2:0];
  endfunction
endpackage

// File: rtl/gip_line_timer.sv
module gip_line_timer #(
  parameter int unsigned NUM_LINES = 1080
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rot,
  input  logic       frame_stb,
  input  logic       line_stb,
  input  logic       vblank,
  output logic       vst_o,
  output logic       run_o,
  output logic [2:0] pos_o,
  output logic       rev_o
);
  import gip_pkg::*;
  localparam int unsigned LAST = NUM_LINES + 2;
  localparam int unsigned CW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] LAST_C  = CW'(LAST);
  localparam logic [CW-1:0] FINAL_C = CW'(NUM_LINES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    pos_q, pos_d;
  logic          rev_q, rev_d;
  logic          step;

  assign step = line_stb && !vblank && (cnt_q != LAST_C);

  always_comb begin
    cnt_d = cnt_q;
    pos_d = pos_q;
    rev_d = rev_q;
    if (!en) begin
      cnt_d = '0;
      pos_d = '0;
      rev_d = 1'b0;
    end else if (frame_stb) begin
      cnt_d = '0;
      pos_d = '0;
      rev_d = rot;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q >= CW'(2))
        pos_d = (pos_q == 3'(PHASES - 1)) ? 3'd0 : pos_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pos_q <= '0;
      rev_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pos_q <= pos_d;
      rev_q <= rev_d;
    end
  end

  assign vst_o = (cnt_q == CW'(1));
  assign run_o = (cnt_q >= CW'(2)) && (cnt_q <= FINAL_C);
  assign pos_o = pos_q;
  assign rev_o = rev_q;
endmodule

// File: rtl/gip_phase_map.sv
module gip_phase_map #(
  parameter int unsigned NPH = 6
) (
  input  logic           run,
  input  logic           rev,
  input  logic [2:0]     pos,
  output logic [NPH-1:0] gclk
);
  import gip_pkg::*;
  logic [2:0] sel;
  assign sel = gate_index(pos, rev);

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    assign gclk[g] = run && (sel == 3'(g));
  end
endmodule

// File: rtl/gip_supply_alt.sv
module gip_supply_alt (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic frame_stb,
  input  logic vblank,
  output logic odd_o,
  output logic even_o
);
  import gip_pkg::*;
  sup_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en) st_d = SUP_ODD;
    else begin
      unique case (st_q)
        SUP_ODD:   if (frame_stb && vblank) st_d = SUP_GAP_E;
        SUP_GAP_E: if (vblank)              st_d = SUP_EVEN;
        SUP_EVEN:  if (frame_stb && vblank) st_d = SUP_GAP_O;
        SUP_GAP_O: if (vblank)              st_d = SUP_ODD;
        default:                            st_d = SUP_ODD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SUP_ODD;
    else        st_q <= st_d;
  end

  assign odd_o  = (st_q == SUP_ODD);
  assign even_o = (st_q == SUP_EVEN);
endmodule

// File: rtl/gip_clock_seq.sv
module gip_clock_seq #(
  parameter int unsigned NUM_LINES = 1080
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rot,
  input  logic       line_stb,
  input  logic       frame_stb,
  input  logic       vblank,
  output logic       vst,
  output logic [5:0] gclk,
  output logic       vgi_p,
  output logic       vgi_n,
  output logic       vgh_odd,
  output logic       vgh_even
);
  import gip_pkg::*;
  logic       vst_i, run_i, rev_i, odd_i, even_i;
  logic [2:0] pos_i;
  logic [PHASES-1:0] gclk_i;

  gip_line_timer #(.NUM_LINES(NUM_LINES)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .rot(rot),
    .frame_stb(frame_stb), .line_stb(line_stb), .vblank(vblank),
    .vst_o(vst_i), .run_o(run_i), .pos_o(pos_i), .rev_o(rev_i)
  );

  gip_phase_map #(.NPH(PHASES)) u_map (
    .run(run_i), .rev(rev_i), .pos(pos_i), .gclk(gclk_i)
  );

  gip_supply_alt u_supply (
    .clk(clk), .rst_n(rst_n), .en(en), .frame_stb(frame_stb),
    .vblank(vblank), .odd_o(odd_i), .even_o(even_i)
  );

  assign vst      = en & vst_i;
  assign gclk     = en ? gclk_i : '0;
  assign vgi_p    = en & ~rot;
  assign vgi_n    = en & rot;
  assign vgh_odd  = en & odd_i;
  assign vgh_even = en & even_i;
endmodule

// File: rtl/gip_clock_seq_chk.sv
module gip_clock_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       line_stb,
  input logic       frame_stb,
  input logic       vblank,
  input logic       vst,
  input logic [5:0] gclk,
  input logic       vgi_p,
  input logic       vgi_n,
  input logic       vgh_odd,
  input logic       vgh_even
);
  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (gclk == 6'd0 && !vst && !vgi_p && !vgi_n && !vgh_odd && !vgh_even));

  // R9
  supply_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vgh_odd && vgh_even));

  // R4
  gclk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gclk));

  // R3
  vst_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vst |-> (gclk == 6'd0));

  // R10
  odd_blank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(vgh_odd)) |-> $past(vblank));

  // R10
  even_blank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(vgh_even)) |-> $past(vblank));

  // R8
  gclk_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(gclk)) |-> $past(line_stb || frame_stb));
endmodule

bind gip_clock_seq gip_clock_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .line_stb(line_stb),
  .frame_stb(frame_stb), .vblank(vblank), .vst(vst), .gclk(gclk),
  .vgi_p(vgi_p), .vgi_n(vgi_n), .vgh_odd(vgh_odd), .vgh_even(vgh_even)
);

// File: tb/gip_clock_seq_test.sv
module gip_clock_seq_test;
  localparam int N    = 1080;
  localparam int LAST = N + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, rot = 1'b0, line_stb = 1'b0, frame_stb = 1'b0, vblank = 1'b1;
  logic vst, vgi_p, vgi_n, vgh_odd, vgh_even;
  logic [5:0] gclk;

  int checks = 0, errors = 0;
  int m_cnt = 0, m_pos = 0, m_sup = 0; // sup: 0 odd,1 gap->even,2 even,3 gap->odd
  logic m_dir = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  gip_clock_seq uut (
    .clk(clk), .rst_n(rst_n), .en(en), .rot(rot), .line_stb(line_stb),
    .frame_stb(frame_stb), .vblank(vblank), .vst(vst), .gclk(gclk),
    .vgi_p(vgi_p), .vgi_n(vgi_n), .vgh_odd(vgh_odd), .vgh_even(vgh_even)
  );

  function automatic logic [5:0] order_bit(int pos, logic dir);
    int idx;
    if (!dir) case (pos) 0: idx = 3; 1: idx = 4; 2: idx = 5; 3: idx = 0; 4: idx = 1; default: idx = 2; endcase
    else      case (pos) 0: idx = 2; 1: idx = 1; 2: idx = 0; 3: idx = 5; 4: idx = 4; default: idx = 3; endcase
    return 6'(1) << idx;
  endfunction

  function automatic logic [5:0] exp_gclk();
    if (!en || m_cnt < 2 || m_cnt > N + 1) return 6'd0;
    return order_bit(m_pos, m_dir);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(string ctx);
    string gr;
    gr = (ctx != "") ? ctx : (m_cnt > N + 1) ? "R7" : (m_dir ? "R5" : "R4");
    chk((ctx != "") ? ctx : "R3", {7'd0, vst}, {7'd0, en && m_cnt == 1});
    chk(gr, {2'd0, gclk}, {2'd0, exp_gclk()});
    chk((ctx != "") ? ctx : "R9", {6'd0, vgh_odd, vgh_even},
        {6'd0, en && m_sup == 0, en && m_sup == 2});
    chk("R2", {6'd0, vgi_p, vgi_n}, {6'd0, en && !rot, en && rot});
  endtask

  task automatic cyc(logic f, logic l, logic vb, string ctx);
    frame_stb = f; line_stb = l; vblank = vb;
    @(posedge clk);
    if (!en) begin m_cnt = 0; m_pos = 0; m_dir = 0; m_sup = 0; end
    else begin
      if (f) begin m_cnt = 0; m_pos = 0; m_dir = rot; end
      else if (l && !vb && m_cnt < LAST) begin
        if (m_cnt >= 2) m_pos = (m_pos + 1) % 6;
        m_cnt++;
      end
      case (m_sup)
        0: if (f && vb) m_sup = 1;
        1: if (vb) m_sup = 2;
        2: if (f && vb) m_sup = 3;
        default: if (vb) m_sup = 0;
      endcase
    end
    #1;
    frame_stb = 0; line_stb = 0;
    compare(ctx);
  endtask

  task automatic run_lines(int n);
    for (int i = 0; i < n; i++) begin
      int gap;
      gap = $urandom_range(0, 2);
      for (int k = 0; k < gap; k++) cyc(0, 0, 0, "");
      cyc(0, 1, 0, "");
    end
  endtask

  task automatic frame_start();
    cyc(1, 0, 1, "R10");
    chk("R10", {6'd0, vgh_odd, vgh_even}, 8'd0);
    cyc(0, 0, 1, "R10");
    cyc(0, 0, 0, "");
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    #1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(0, 0, 1, "R1");
    cyc(0, 1, 1, "R1");
    en = 1'b1;
    #1 chk("R9", {6'd0, vgh_odd, vgh_even}, 8'b10);
    cyc(0, 0, 1, "R9");

    // normal full frame
    rot = 0;
    frame_start();
    run_lines(3);
    chk("R3", {7'd0, vst}, 8'd0);
    run_lines(N + 2);
    run_lines(2);
    // blanking with ignored line strobes
    cyc(0, 0, 1, "R8");
    cyc(0, 1, 1, "R8");
    cyc(0, 1, 1, "R8");

    // reverse frame, rot changed mid-frame
    rot = 1;
    frame_start();
    run_lines(20);
    rot = 0;
    run_lines(15);
    cyc(0, 0, 0, "R6");
    rot = 1;
    run_lines(N);

    // frame strobe outside blanking: restarts lines, no swap
    rot = 0;
    cyc(1, 0, 0, "R11");
    run_lines(8);
    // frame and line strobe together
    cyc(1, 1, 0, "R12");
    chk("R12", {7'd0, vst}, 8'd0);
    run_lines(2);
    // swap, gap held while blanking low
    cyc(0, 0, 1, "R10");
    cyc(1, 1, 1, "R10");
    cyc(0, 0, 0, "R10");
    cyc(0, 0, 0, "R10");
    cyc(0, 0, 1, "R10");
    run_lines(N + 3);

    // disable mid-frame then re-enable
    en = 0;
    cyc(0, 1, 0, "R1");
    chk("R1", {2'd0, gclk}, 8'd0);
    en = 1;
    #1 chk("R9", {6'd0, vgh_odd, vgh_even}, 8'b10);
    frame_start();
    run_lines(30);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule